// File: doc/BRIEF.md
# Extended Memory Bank Address Selector

This block drives the three upper address lines of a static RAM used as a memory expansion for an 8-bit computer. Two masters share that memory bus: the processor, and a video DMA controller that steals bus cycles by pulling an active-low halt line. Each master has its own enable bit in a parallel I/O port. When a master's enable bit is low, that master's accesses to the 16 KB banked window are redirected to one of four extended banks. A further pair of port bits chooses the bank. All other accesses go to main memory unchanged.

The halt line comes from combinational logic in the DMA controller, so it settles late in a cycle. The DMA controller also raises it one cycle before the cycle it takes over. For these reasons the block never uses halt directly. It samples halt on the falling edge of phase 2 and uses that registered owner flag for the next memory access. The port bits are captured on the same edge. The address presented during a phase-2 high period therefore depends only on state captured at the preceding falling edge and on the processor's own address lines. All pins are plain level signals; there is no streamed data path and no handshake.

Top module: `ext_bank_addr_sel`

## Requirements
- R1: While reset is held, and after it is released up to the first phase-2 falling edge, the block maps every address as normal memory (SRAM A16 low, SRAM A15/A14 equal to CPU A15/A14). This holds even with halt asserted and every port bit driven low, because reset clears the owner flag to processor and treats the port bits as high.
- R2: The halt input is sampled at the phase-2 falling edge. A level driven during cycle N selects the bus owner for cycle N+1 only. Low means DMA and high means processor.
- R3: With both enable bits high (cpu_xmem_n = 1, vid_xmem_n = 1), SRAM A16 is 0 and CPU A15/A14 pass straight through to SRAM A15/A14.
- R4: In a processor-owned cycle with cpu_xmem_n = 0 and an address in the window, SRAM A16 is 1, SRAM A14 = port_bank[0] and SRAM A15 = port_bank[1].
- R5: In a DMA-owned cycle with vid_xmem_n = 0 and an address in the window, the block applies the same mapping as R4: A16 = 1, A14 = port_bank[0], A15 = port_bank[1].
- R6: cpu_xmem_n low does not redirect DMA-owned cycles, and vid_xmem_n low does not redirect processor-owned cycles. Such cycles get the normal mapping.
- R7: Extended memory is selected only inside the window where CPU A15 = 0 and CPU A14 = 1. Every other address gets the normal mapping regardless of enables and owner.
- R8: Changes to halt_n, the enable bits or port_bank while phase 2 is high do not alter the outputs before the next phase-2 falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi2 | input | 1 | Phase-2 bus clock; the falling edge is the sampling instant |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_n | input | 1 | Active-low cycle-steal request from the video DMA controller |
| cpu_a14 | input | 1 | Processor address line 14 |
| cpu_a15 | input | 1 | Processor address line 15 |
| port_bank | input | 2 | Extended bank number from the I/O port (bit 0 to SRAM A14, bit 1 to SRAM A15) |
| cpu_xmem_n | input | 1 | Active-low extended-memory enable for processor cycles |
| vid_xmem_n | input | 1 | Active-low extended-memory enable for DMA cycles |
| sram_a14 | output | 1 | SRAM address line 14 |
| sram_a15 | output | 1 | SRAM address line 15 |
| sram_a16 | output | 1 | SRAM address line 16, high for extended memory |

## Verification
The bench drives halt just after each phase-2 rising edge and checks the mapping one cycle later, across all four enable combinations. A design that used halt without a register, or sampled it on the wrong edge, would redirect the current cycle instead of the next one. It also toggles halt and the port bits mid-way through a phase-2 high period; a design with a transparent path would show the address changing inside the access. Cross checks drive one enable with the other master owning the bus, which catches a design that ORs the two enables. All four address quadrants are tried with both enables low, which catches a missing or mis-decoded window.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

  localparam int BANK_W = 2;

  typedef enum logic {
    OWNER_CPU = 1'b0,
    OWNER_DMA = 1'b1
  } owner_e;

  typedef struct packed {
    logic              vid_en_n;
    logic              cpu_en_n;
    logic [BANK_W-1:0] bank;
  } port_snap_t;

  localparam port_snap_t SNAP_RESET = '{vid_en_n: 1'b1, cpu_en_n: 1'b1, bank: '1};

endpackage

// File: rtl/bsel_halt_sync.sv
module bsel_halt_sync
  import bank_sel_pkg::*;
(
  input  logic   phi2,
  input  logic   rst_n,
  input  logic   halt_n,
  output owner_e owner_q
);

  // Captured at the phase-2 falling edge; governs the following access.
  always_ff @(negedge phi2 or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWNER_CPU;
    end else if (!halt_n) begin
      owner_q <= OWNER_DMA;
    end else begin
      owner_q <= OWNER_CPU;
    end
  end

endmodule

// File: rtl/bsel_port_snap.sv
module bsel_port_snap
  import bank_sel_pkg::*;
(
  input  logic              phi2,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] port_bank,
  input  logic              cpu_xmem_n,
  input  logic              vid_xmem_n,
  output port_snap_t        snap_q
);

  port_snap_t snap_d;

  always_comb begin
    snap_d.bank     = port_bank;
    snap_d.cpu_en_n = cpu_xmem_n;
    snap_d.vid_en_n = vid_xmem_n;
  end

  always_ff @(negedge phi2 or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= SNAP_RESET;
    end else begin
      snap_q <= snap_d;
    end
  end

endmodule

// File: rtl/bsel_window_dec.sv
module bsel_window_dec #(
  parameter logic WIN_A15 = 1'b0,
  parameter logic WIN_A14 = 1'b1
) (
  input  logic cpu_a14,
  input  logic cpu_a15,
  output logic in_window
);

  always_comb begin
    in_window = (cpu_a15 == WIN_A15) && (cpu_a14 == WIN_A14);
  end

endmodule

// File: rtl/bsel_addr_mux.sv
module bsel_addr_mux
  import bank_sel_pkg::*;
(
  input  owner_e            owner_q,
  input  port_snap_t        snap_q,
  input  logic              in_window,
  input  logic [BANK_W-1:0] cpu_hi,
  output logic [BANK_W-1:0] sram_lo,
  output logic              sram_ext
);

  logic owner_enabled;

  always_comb begin
    unique case (owner_q)
      OWNER_DMA: owner_enabled = !snap_q.vid_en_n;
      default:   owner_enabled = !snap_q.cpu_en_n;
    endcase
    sram_ext = in_window && owner_enabled;
  end

  for (genvar gi = 0; gi < BANK_W; gi++) begin : g_bit
    assign sram_lo[gi] = sram_ext ? snap_q.bank[gi] : cpu_hi[gi];
  end

endmodule

// File: rtl/ext_bank_addr_sel.sv
module ext_bank_addr_sel
  import bank_sel_pkg::*;
#(
  parameter logic WIN_A15 = 1'b0,
  parameter logic WIN_A14 = 1'b1
) (
  input  logic              phi2,
  input  logic              rst_n,
  input  logic              halt_n,
  input  logic              cpu_a14,
  input  logic              cpu_a15,
  input  logic [BANK_W-1:0] port_bank,
  input  logic              cpu_xmem_n,
  input  logic              vid_xmem_n,
  output logic              sram_a14,
  output logic              sram_a15,
  output logic              sram_a16
);

  owner_e            owner_q;
  port_snap_t        snap_q;
  logic              in_window;
  logic [BANK_W-1:0] sram_lo;
  logic              sram_ext;

  bsel_halt_sync u_halt (
    .phi2    (phi2),
    .rst_n   (rst_n),
    .halt_n  (halt_n),
    .owner_q (owner_q)
  );

  bsel_port_snap u_snap (
    .phi2       (phi2),
    .rst_n      (rst_n),
    .port_bank  (port_bank),
    .cpu_xmem_n (cpu_xmem_n),
    .vid_xmem_n (vid_xmem_n),
    .snap_q     (snap_q)
  );

  bsel_window_dec #(.WIN_A15(WIN_A15), .WIN_A14(WIN_A14)) u_win (
    .cpu_a14   (cpu_a14),
    .cpu_a15   (cpu_a15),
    .in_window (in_window)
  );

  bsel_addr_mux u_mux (
    .owner_q   (owner_q),
    .snap_q    (snap_q),
    .in_window (in_window),
    .cpu_hi    ({cpu_a15, cpu_a14}),
    .sram_lo   (sram_lo),
    .sram_ext  (sram_ext)
  );

  assign sram_a14 = sram_lo[0];
  assign sram_a15 = sram_lo[1];
  assign sram_a16 = sram_ext;

  AST_OWNER_FROM_PREV_HALT: assert property (@(negedge phi2) disable iff (!rst_n)
    $past(rst_n) |-> ((owner_q == OWNER_DMA) == !$past(halt_n))); // R2

  AST_NORMAL_PASSTHRU: assert property (@(posedge phi2) disable iff (!rst_n)
    !sram_a16 |-> (sram_a14 == cpu_a14 && sram_a15 == cpu_a15)); // R3

  AST_EXT_BANK_BITS: assert property (@(posedge phi2) disable iff (!rst_n)
    sram_a16 |-> ({sram_a15, sram_a14} == snap_q.bank)); // R4

  AST_CPU_OWN_ENABLE: assert property (@(posedge phi2) disable iff (!rst_n)
    (sram_a16 && owner_q == OWNER_CPU) |-> !snap_q.cpu_en_n); // R6

  AST_DMA_OWN_ENABLE: assert property (@(posedge phi2) disable iff (!rst_n)
    (sram_a16 && owner_q == OWNER_DMA) |-> !snap_q.vid_en_n); // R6

  AST_WINDOW_ONLY: assert property (@(posedge phi2) disable iff (!rst_n)
    sram_a16 |-> (cpu_a15 == WIN_A15 && cpu_a14 == WIN_A14)); // R7

endmodule

// File: tb/ext_bank_addr_sel_bench.sv
module ext_bank_addr_sel_bench;

  localparam int CLK_PERIOD = 20;

  logic       phi2 = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_n = 1'b1;
  logic       cpu_a14 = 1'b0;
  logic       cpu_a15 = 1'b0;
  logic [1:0] port_bank = 2'b00;
  logic       cpu_xmem_n = 1'b1;
  logic       vid_xmem_n = 1'b1;
  logic       sram_a14, sram_a15, sram_a16;

  int checks = 0;
  int fails  = 0;

  // Values presented during the previous cycle, i.e. captured at the last falling edge.
  bit       p_halt_n = 1'b1;
  bit       p_cpu_n  = 1'b1;
  bit       p_vid_n  = 1'b1;
  bit [1:0] p_bank   = 2'b00;

  ext_bank_addr_sel u_ext_bank_addr_sel (
    .phi2       (phi2),
    .rst_n      (rst_n),
    .halt_n     (halt_n),
    .cpu_a14    (cpu_a14),
    .cpu_a15    (cpu_a15),
    .port_bank  (port_bank),
    .cpu_xmem_n (cpu_xmem_n),
    .vid_xmem_n (vid_xmem_n),
    .sram_a14   (sram_a14),
    .sram_a15   (sram_a15),
    .sram_a16   (sram_a16)
  );

  always #(CLK_PERIOD/2) phi2 = ~phi2;

  // Expected {A16, A15, A14} from the requirements.
  function automatic bit [2:0] model(bit dma, bit cn, bit vn, bit [1:0] bk, bit a15, bit a14);
    bit win;
    bit ext;
    win = !a15 && a14;
    ext = win && (dma ? !vn : !cn);
    return ext ? {1'b1, bk[1], bk[0]} : {1'b0, a15, a14};
  endfunction

  task automatic check(input bit [2:0] exp, input string req);
    bit [2:0] act;
    act = {sram_a16, sram_a15, sram_a14};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {a16,a15,a14} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One bus cycle: set this cycle's address and next cycle's halt/port, then check.
  task automatic step(input bit a15, input bit a14, input bit nh, input bit cn,
                      input bit vn, input bit [1:0] bk, input string req);
    @(posedge phi2);
    #1;
    cpu_a15 = a15; cpu_a14 = a14;
    halt_n = nh; cpu_xmem_n = cn; vid_xmem_n = vn; port_bank = bk;
    #2;
    check(model(!p_halt_n, p_cpu_n, p_vid_n, p_bank, a15, a14), req);
    p_halt_n = nh; p_cpu_n = cn; p_vid_n = vn; p_bank = bk;
  endtask

  task automatic test_reset;
    rst_n = 1'b0; halt_n = 1'b0; cpu_xmem_n = 1'b0; vid_xmem_n = 1'b0;
    port_bank = 2'b11; cpu_a15 = 1'b0; cpu_a14 = 1'b1;
    repeat (3) @(posedge phi2);
    #3; check(3'b001, "R1 in reset");
    @(posedge phi2);
    #1; rst_n = 1'b1;
    #2; check(3'b001, "R1 after release");
    p_halt_n = 1'b0; p_cpu_n = 1'b0; p_vid_n = 1'b0; p_bank = 2'b11;
  endtask

  task automatic test_normal;
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, "R3 settle");
    for (int a = 0; a < 4; a++) begin
      step(a[1], a[0], a[0], 1'b1, 1'b1, 2'b11, "R3 normal");
    end
  endtask

  task automatic test_cpu_bank;
    for (int b = 0; b < 4; b++) begin
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, b[1:0], "R4 cpu bank");
    end
  endtask

  task automatic test_video_bank;
    for (int b = 0; b < 4; b++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, b[1:0], "R5 video bank");
    end
  endtask

  task automatic test_isolation;
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, "R6 setup");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, "R6 cpu_en with dma owner");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, "R6 vid_en with cpu owner");
    if (sram_a16 !== 1'b0) begin
      fails++;
      $display("FAIL R6: a16 actual %b expected 0", sram_a16);
    end
    checks++;
  endtask

  task automatic test_window;
    for (int o = 0; o < 2; o++) begin
      for (int a = 0; a < 4; a++) begin
        step(a[1], a[0], o[0], 1'b0, 1'b0, 2'b01, "R7 window decode");
      end
    end
  endtask

  task automatic test_latency;
    bit [4:0] pat;
    pat = 5'b10110;
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 5; i++) begin
        step(1'b0, 1'b1, pat[i], c[0], c[1], 2'b10, "R2 halt latency");
      end
    end
  endtask

  task automatic test_midcycle;
    bit [2:0] exp;
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01, "R8 setup");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01, "R8 before");
    exp = model(1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1);
    #2;
    halt_n = 1'b0; cpu_xmem_n = 1'b1; vid_xmem_n = 1'b0; port_bank = 2'b10;
    #2;
    check(exp, "R8 mid-high perturbation");
    #1;
    halt_n = 1'b1; cpu_xmem_n = 1'b0; vid_xmem_n = 1'b1; port_bank = 2'b01;
  endtask

  initial begin
    test_reset;
    test_normal;
    test_cpu_bank;
    test_video_bank;
    test_isolation;
    test_window;
    test_latency;
    test_midcycle;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule